// File: doc/BRIEF.md
# Serial Peripheral Interface Controller with Fault Detection

This block is a byte-oriented synchronous serial port that works as master or slave. Software reaches it through three byte-wide registers: a control register, a status register, and one data register. The data register holds the transmit byte on a write and returns the last received byte on a read. In master mode the block produces the serial clock from the system clock through a selectable divider. It shifts eight bits MSB first, in any of the four clock polarity/phase combinations. In slave mode it follows an external clock and select. The slave pins pass through a two-flop synchronizer, so the slave clock must be slow compared with the system clock.

Transmit has a single buffer. A data-register write goes straight into the shift register. If a write arrives while a frame is moving, the block discards the write and records a collision. The frame in progress is not disturbed.

The block also checks for bus contention. If the select input is driven active while the block is enabled as master, the block does three things: it withdraws its own master and enable bits, it releases every pin it drives, and it records a fault. A flag-based interrupt request is gated by an enable bit and by an external mask input. The select pin can instead be used as an output. In that case fault checking is off and the pin marks the frames the master sends.

Top module: `spi_ctl`

## Requirements
- R1: After reset, the control, status and data registers read 0x00, `reg_rdata` is 0x00, `irq` is low, and the output enables `sck_oe`, `mosi_oe`, `miso_oe` and `ss_oe` are all low.
- R2: A data write (`reg_addr`=2) while control bit 6 (enable) and bit 4 (master) are set and no frame is moving starts a frame. The block puts out 16 serial clock edges and sends the byte MSB first on `mosi_out`. It shifts in `miso_in`, sets status bit 7, and makes the received byte readable at `reg_addr`=2.
- R3: Control bits 1:0 pick the serial clock period: 0, 1, 2 and 3 give 2, 4, 16 and 32 system clocks. The first clock edge comes half a period after the data write, and the sixteen edges are half a period apart.
- R4: Control bit 3 sets the idle level of `sck_out`. Control bit 2 set to 0 samples data on the leading edge and changes it on the trailing edge; set to 1 it does the reverse.
- R5: A data write while a frame is moving is ignored. This holds in master mode, and in slave mode while the select input is low. The block sets status bit 6, and the current frame completes with its original byte.
- R6: Status bits 7 and 6 clear only when a status read that saw them set is followed by a read or write of the data register. A data access without that earlier read leaves them set.
- R7: With control bits 6 and 4 set, control bit 5 clear, and `ss_n_in` low, the block raises a fault. Status bit 4 sets, control bits 6 and 4 clear, and `sck_oe` and `mosi_oe` drop. A status read followed by a control write clears status bit 4.
- R8: With control bit 5 set, `ss_oe` is high and no fault is raised. `ss_n_out` is low while a master frame is moving and high otherwise.
- R9: `irq` is high one cycle after control bit 7 is set, `irq_mask` is low, and status bit 7 or bit 4 is set. `irq` is low whenever `irq_mask` was high in the previous cycle.
- R10: With control bit 6 set and bit 4 clear, the block acts as slave. It shifts on the synchronized `sck_in` while `ss_n_in` is low, in all four clock modes. The byte from `mosi_in` lands in the data register with status bit 7 set. The loaded byte goes out MSB first on `miso_out`, and `miso_oe` is high only while `ss_n_in` is low.
- R11: In slave mode, a rise of `ss_n_in` in the middle of a byte discards the partial frame without setting status bit 7. The next frame starts again from its first bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data, valid the cycle after the read strobe |
| irq_mask | input | 1 | Global interrupt mask, high blocks `irq` |
| irq | output | 1 | Registered interrupt request |
| sck_in | input | 1 | Serial clock from an external master |
| sck_out | output | 1 | Serial clock driven in master mode |
| sck_oe | output | 1 | Output enable for the serial clock pin |
| mosi_in | input | 1 | Serial data in, slave mode |
| mosi_out | output | 1 | Serial data out, master mode |
| mosi_oe | output | 1 | Output enable for the master data-out pin |
| miso_in | input | 1 | Serial data in, master mode |
| miso_out | output | 1 | Serial data out, slave mode |
| miso_oe | output | 1 | Output enable for the slave data-out pin |
| ss_n_in | input | 1 | Active-low select input |
| ss_n_out | output | 1 | Select level when the select pin is an output |
| ss_oe | output | 1 | Output enable for the select pin |

## Verification
If the bit counter or the edge counter is wrong, the number of edges on `sck_out` changes, or the received byte comes back rotated by a bit. Either shows in the data read right after the frame, within one frame time. A wrong half-period count moves the first edge or changes the edge spacing within a single frame at the affected rate. The sweep covers every rate in every mode, so such an error cannot hide behind the timing of another rate. Faults in the flag arming or the fault logic show in the next status read, in the control readback, or within two cycles on `irq` and the pin enables.

// File: rtl/spi_ctl_pkg.sv
package spi_ctl_pkg;
  localparam int BYTE_W = 8;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_DATA = 2'd2;

  // control field positions
  localparam int C_IE   = 7;
  localparam int C_EN   = 6;
  localparam int C_SSO  = 5;
  localparam int C_MST  = 4;
  localparam int C_CPOL = 3;
  localparam int C_CPHA = 2;

  // status field positions
  localparam int S_DONE = 7;
  localparam int S_COLL = 6;
  localparam int S_FLT  = 4;

  // half of the serial clock period, in system clocks
  function automatic logic [4:0] half_period(input logic [1:0] rate);
    case (rate)
      2'd0:    half_period = 5'd1;
      2'd1:    half_period = 5'd2;
      2'd2:    half_period = 5'd8;
      default: half_period = 5'd16;
    endcase
  endfunction
endpackage

// File: rtl/spi_ctl_sync.sv
module spi_ctl_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= RST_VAL;
    end else begin
      stage[0] <= d;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/spi_ctl_sckgen.sv
module spi_ctl_sckgen #(
  parameter int HALF_W = 5,
  parameter int EDGES  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              halt,
  input  logic              cpol,
  input  logic [HALF_W-1:0] half,
  output logic              sck,
  output logic              busy,
  output logic              lead,
  output logic              trail
);
  localparam int K_W = $clog2(EDGES);
  localparam logic [K_W-1:0] K_LAST = K_W'(EDGES - 1);

  logic [HALF_W-1:0] hcnt;
  logic [K_W-1:0]    k;
  logic              tick;

  assign tick  = busy && (hcnt == half - HALF_W'(1));
  assign lead  = tick && !k[0];
  assign trail = tick && k[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      hcnt <= '0;
      k    <= '0;
      sck  <= 1'b0;
    end else if (halt) begin
      busy <= 1'b0;
      hcnt <= '0;
      k    <= '0;
      sck  <= cpol;
    end else if (start) begin
      busy <= 1'b1;
      hcnt <= '0;
      k    <= '0;
      sck  <= cpol;
    end else if (busy) begin
      if (tick) begin
        hcnt <= '0;
        sck  <= ~sck;
        k    <= k + K_W'(1);
        if (k == K_LAST) busy <= 1'b0;
      end else begin
        hcnt <= hcnt + HALF_W'(1);
      end
    end else begin
      sck <= cpol;
    end
  end
endmodule

// File: rtl/spi_ctl_shift.sv
module spi_ctl_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         lead,
  input  logic         trail,
  input  logic         cpha,
  input  logic         din,
  input  logic         abort,
  output logic         dout,
  output logic         done,
  output logic [W-1:0] frame
);
  localparam int CNT_W = $clog2(W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

  logic [W-1:0]     sr;
  logic             held;
  logic [CNT_W-1:0] cnt;

  assign dout  = sr[W-1];
  assign done  = trail && !abort && !load && (cnt == LAST);
  assign frame = {sr[W-2:0], cpha ? din : held};

  always_ff @(posedge clk) begin
    if (rst) begin
      sr   <= '0;
      held <= 1'b0;
      cnt  <= '0;
    end else if (load) begin
      sr  <= load_val;
      cnt <= '0;
    end else if (abort) begin
      cnt <= '0;
    end else begin
      if (lead) begin
        if (!cpha)           held <= din;
        else if (cnt != '0)  sr   <= {sr[W-2:0], held};
      end
      if (trail) begin
        cnt <= (cnt == LAST) ? '0 : cnt + CNT_W'(1);
        if (!cpha)             sr   <= {sr[W-2:0], held};
        else if (cnt == LAST)  sr   <= {sr[W-2:0], din};
        else                   held <= din;
      end
    end
  end
endmodule

// File: rtl/spi_ctl.sv
module spi_ctl
  import spi_ctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int HALF_W      = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  input  logic              irq_mask,
  output logic              irq,
  input  logic              sck_in,
  output logic              sck_out,
  output logic              sck_oe,
  input  logic              mosi_in,
  output logic              mosi_out,
  output logic              mosi_oe,
  input  logic              miso_in,
  output logic              miso_out,
  output logic              miso_oe,
  input  logic              ss_n_in,
  output logic              ss_n_out,
  output logic              ss_oe
);
  logic [BYTE_W-1:0] ctrl, rxbuf, status;
  logic f_done, f_coll, f_flt;
  logic arm_done, arm_coll, arm_flt;

  logic en, mst, sso, cpol, cpha, ie;
  assign ie   = ctrl[C_IE];
  assign en   = ctrl[C_EN];
  assign sso  = ctrl[C_SSO];
  assign mst  = ctrl[C_MST];
  assign cpol = ctrl[C_CPOL];
  assign cpha = ctrl[C_CPHA];

  // synchronized slave-side pins: {select, data, clock}
  logic ss_s, mosi_s, sck_s, ss_d, sck_d;
  spi_ctl_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst(rst),
    .d({ss_n_in, mosi_in, sck_in}),
    .q({ss_s, mosi_s, sck_s})
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ss_d  <= 1'b1;
      sck_d <= 1'b0;
    end else begin
      ss_d  <= ss_s;
      sck_d <= sck_s;
    end
  end

  logic slave, s_sel, s_rise, s_fall, s_lead, s_trail;
  assign slave   = en && !mst;
  assign s_sel   = slave && !ss_s;
  assign s_rise  = sck_s && !sck_d;
  assign s_fall  = !sck_s && sck_d;
  assign s_lead  = s_sel && (cpol ? s_fall : s_rise);
  assign s_trail = s_sel && (cpol ? s_rise : s_fall);

  // register access decode
  logic wr_ctrl, rd_stat, wr_data, data_acc;
  assign wr_ctrl  = reg_wr && (reg_addr == A_CTRL);
  assign rd_stat  = reg_rd && (reg_addr == A_STAT);
  assign wr_data  = reg_wr && (reg_addr == A_DATA);
  assign data_acc = (reg_wr || reg_rd) && (reg_addr == A_DATA);

  logic fault, m_busy, busy, coll, load, start, halt;
  assign fault = en && mst && !sso && !ss_s;
  assign busy  = (en && mst && m_busy) || s_sel;
  assign coll  = wr_data && busy;
  assign load  = wr_data && !busy;
  assign start = load && en && mst && !fault;
  assign halt  = fault || !(en && mst);

  logic m_lead, m_trail, sck_q;
  spi_ctl_sckgen #(.HALF_W(HALF_W), .EDGES(2 * BYTE_W)) u_sckgen (
    .clk(clk), .rst(rst), .start(start), .halt(halt), .cpol(cpol),
    .half(HALF_W'(half_period(ctrl[1:0]))),
    .sck(sck_q), .busy(m_busy), .lead(m_lead), .trail(m_trail)
  );

  logic sh_dout, sh_done, sh_abort;
  logic [BYTE_W-1:0] sh_frame;
  assign sh_abort = fault || (slave && ss_s && !ss_d);

  spi_ctl_shift #(.W(BYTE_W)) u_shift (
    .clk(clk), .rst(rst), .load(load), .load_val(reg_wdata),
    .lead(mst ? m_lead : s_lead), .trail(mst ? m_trail : s_trail),
    .cpha(cpha), .din(mst ? miso_in : mosi_s), .abort(sh_abort),
    .dout(sh_dout), .done(sh_done), .frame(sh_frame)
  );

  always_comb begin
    status         = '0;
    status[S_DONE] = f_done;
    status[S_COLL] = f_coll;
    status[S_FLT]  = f_flt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl      <= '0;
      rxbuf     <= '0;
      f_done    <= 1'b0;
      f_coll    <= 1'b0;
      f_flt     <= 1'b0;
      arm_done  <= 1'b0;
      arm_coll  <= 1'b0;
      arm_flt   <= 1'b0;
      reg_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      if (fault) begin
        ctrl[C_EN]  <= 1'b0;
        ctrl[C_MST] <= 1'b0;
      end else if (wr_ctrl) begin
        ctrl <= reg_wdata;
      end

      if (sh_done) rxbuf <= sh_frame;

      if (sh_done)                     f_done <= 1'b1;
      else if (data_acc && arm_done)   f_done <= 1'b0;
      if (coll)                        f_coll <= 1'b1;
      else if (data_acc && arm_coll)   f_coll <= 1'b0;
      if (fault)                       f_flt  <= 1'b1;
      else if (wr_ctrl && arm_flt)     f_flt  <= 1'b0;

      if (rd_stat) begin
        arm_done <= f_done;
        arm_coll <= f_coll;
      end else if (data_acc) begin
        arm_done <= 1'b0;
        arm_coll <= 1'b0;
      end
      if (rd_stat)      arm_flt <= f_flt;
      else if (wr_ctrl) arm_flt <= 1'b0;

      if (reg_rd) begin
        case (reg_addr)
          A_CTRL:  reg_rdata <= ctrl;
          A_STAT:  reg_rdata <= status;
          A_DATA:  reg_rdata <= rxbuf;
          default: reg_rdata <= '0;
        endcase
      end

      irq <= ie && !irq_mask && (f_done || f_flt);
    end
  end

  assign sck_out  = sck_q;
  assign sck_oe   = en && mst;
  assign mosi_out = sh_dout;
  assign mosi_oe  = en && mst;
  assign miso_out = sh_dout;
  assign miso_oe  = s_sel;
  assign ss_oe    = sso;
  assign ss_n_out = !(mst && m_busy);
endmodule

// File: rtl/spi_ctl_chk.sv
module spi_ctl_chk (
  input logic clk,
  input logic rst,
  input logic m_busy,
  input logic cpol,
  input logic sck_out,
  input logic sck_oe,
  input logic mosi_oe,
  input logic f_flt,
  input logic f_coll,
  input logic coll,
  input logic data_acc,
  input logic irq,
  input logic irq_mask
);
  // R4: between frames the serial clock sits at the programmed idle level
  a_r4_sck_idle: assert property (@(posedge clk) disable iff (rst)
    $past(!m_busy) |-> (sck_out == $past(cpol)));

  // R7: a new fault leaves the master pins released
  a_r7_pins_released: assert property (@(posedge clk) disable iff (rst)
    $rose(f_flt) |-> (!sck_oe && !mosi_oe));

  // R5: a rejected data write always leaves the collision flag set
  a_r5_coll_flag: assert property (@(posedge clk) disable iff (rst)
    coll |=> f_coll);

  // R6: the collision flag survives any cycle without a data access
  a_r6_coll_sticky: assert property (@(posedge clk) disable iff (rst)
    (f_coll && !data_acc) |=> f_coll);

  // R9: the global mask silences the request on the next cycle
  a_r9_mask_blocks: assert property (@(posedge clk) disable iff (rst)
    irq_mask |=> !irq);
endmodule

bind spi_ctl spi_ctl_chk u_chk (
  .clk(clk), .rst(rst), .m_busy(m_busy), .cpol(cpol), .sck_out(sck_out),
  .sck_oe(sck_oe), .mosi_oe(mosi_oe), .f_flt(f_flt), .f_coll(f_coll),
  .coll(coll), .data_acc(data_acc), .irq(irq), .irq_mask(irq_mask)
);

// File: tb/spi_ctl_tb.sv
module spi_ctl_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] reg_addr = 2'd0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic irq_mask = 1'b0, irq;
  logic tb_sck = 1'b0, tb_mosi = 1'b0, tb_miso = 1'b0, tb_ss = 1'b1;
  logic sck_out, sck_oe, mosi_out, mosi_oe, miso_out, miso_oe, ss_n_out, ss_oe;
  logic miso_line;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  assign miso_line = mosi_oe ? mosi_out : tb_miso;

  spi_ctl u_dut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_mask(irq_mask), .irq(irq),
    .sck_in(tb_sck), .sck_out(sck_out), .sck_oe(sck_oe),
    .mosi_in(tb_mosi), .mosi_out(mosi_out), .mosi_oe(mosi_oe),
    .miso_in(miso_line), .miso_out(miso_out), .miso_oe(miso_oe),
    .ss_n_in(tb_ss), .ss_n_out(ss_n_out), .ss_oe(ss_oe)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] v);
    @(negedge clk);
    reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    v = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // bench acting as external master; H system clocks per half period
  task automatic ext_frame(input bit cpol, input bit cpha, input logic [7:0] mb,
                           input int nbits, output logic [7:0] seen, output bit oe_seen);
    localparam int H = 8;
    seen = 8'h00; oe_seen = 1'b1;
    tb_sck = cpol; tb_ss = 1'b0;
    idle(H);
    for (int i = 0; i < nbits; i++) begin
      if (!cpha) begin
        tb_mosi = mb[7-i];
        idle(H);
        seen = {seen[6:0], miso_out};
        oe_seen = oe_seen & miso_oe;
        tb_sck = ~cpol;
        idle(H);
        tb_sck = cpol;
      end else begin
        idle(H);
        tb_sck = ~cpol;
        tb_mosi = mb[7-i];
        idle(H);
        seen = {seen[6:0], miso_out};
        oe_seen = oe_seen & miso_oe;
        tb_sck = cpol;
      end
    end
    idle(H);
    tb_ss = 1'b1;
    idle(6);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 32'd0, 32'd1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v, seen;
    bit oe_seen;
    idle(4);
    rst = 1'b0;
    idle(1);

    // R1 reset state
    check(reg_rdata == 8'h00, "R1 rdata", reg_rdata, 0);
    check({sck_oe, mosi_oe, miso_oe, ss_oe, irq} == 5'b0, "R1 enables/irq",
          {sck_oe, mosi_oe, miso_oe, ss_oe, irq}, 0);
    bus_rd(2'd0, v); check(v == 8'h00, "R1 control", v, 0);
    bus_rd(2'd1, v); check(v == 8'h00, "R1 status", v, 0);
    bus_rd(2'd2, v); check(v == 8'h00, "R1 data", v, 0);

    // R2/R3/R4 master sweep: every mode, every rate, several bytes, loopback
    for (int mode = 0; mode < 4; mode++) begin
      for (int rate = 0; rate < 4; rate++) begin
        for (int p = 0; p < 4; p++) begin
          automatic bit cpol = mode[1];
          automatic bit cpha = mode[0];
          automatic int half = (rate == 0) ? 1 : (rate == 1) ? 2 : (rate == 2) ? 8 : 16;
          automatic logic [7:0] tx = 8'(8'hA5 + p * 8'h3B + mode * 8'h11 + rate);
          automatic logic ps, pm;
          automatic int ntog = 0, first = 0, last = 0;
          automatic logic [7:0] cap = 8'h00;
          bus_wr(2'd0, 8'h50 | 8'(cpol << 3) | 8'(cpha << 2) | 8'(rate));
          idle(1);
          check(sck_out == cpol, "R4 idle level", sck_out, cpol);
          bus_wr(2'd2, tx);
          ps = sck_out; pm = mosi_out;
          for (int n = 1; n <= 700 && ntog < 16; n++) begin
            @(negedge clk);
            if (sck_out !== ps) begin
              if (ntog == 0) first = n;
              last = n;
              if (((ntog % 2) == 0) == (cpha == 1'b0)) cap = {cap[6:0], pm};
              ntog++;
            end
            ps = sck_out; pm = mosi_out;
          end
          check(ntog == 16, "R2 edge count", ntog, 16);
          check(first == half, "R3 first edge", first, half);
          check(last - first == 15 * half, "R3 edge spacing", last - first, 15 * half);
          check(cap == tx, "R4 bits at sampling edge", cap, tx);
          check(sck_out == cpol, "R4 back to idle", sck_out, cpol);
          bus_rd(2'd1, v); check(v == 8'h80, "R2 done flag", v, 8'h80);
          bus_rd(2'd2, v); check(v == tx, "R2 received byte", v, tx);
          bus_rd(2'd1, v); check(v == 8'h00, "R6 cleared by sequence", v, 0);
        end
      end
    end

    // R6 data access without a prior status read keeps the flag
    bus_wr(2'd0, 8'h50);
    bus_wr(2'd2, 8'h3C);
    idle(30);
    bus_rd(2'd2, v); check(v == 8'h3C, "R6 data", v, 8'h3C);
    bus_rd(2'd1, v); check(v == 8'h80, "R6 flag kept", v, 8'h80);
    bus_rd(2'd2, v);
    bus_rd(2'd1, v); check(v == 8'h00, "R6 flag cleared", v, 0);

    // R5 collision in master mode
    bus_wr(2'd0, 8'h51);
    bus_wr(2'd2, 8'h96);
    idle(4);
    bus_wr(2'd2, 8'h0F);
    idle(40);
    bus_rd(2'd1, v); check(v == 8'hC0, "R5 collision flag", v, 8'hC0);
    bus_rd(2'd2, v); check(v == 8'h96, "R5 frame unchanged", v, 8'h96);
    bus_rd(2'd1, v); check(v == 8'h00, "R6 both cleared", v, 0);

    // R5 collision in slave mode
    bus_wr(2'd0, 8'h40);
    tb_ss = 1'b0; idle(4);
    bus_wr(2'd2, 8'h77);
    bus_rd(2'd1, v); check(v == 8'h40, "R5 slave collision", v, 8'h40);
    tb_ss = 1'b1; idle(4);
    bus_rd(2'd2, v);
    bus_rd(2'd1, v); check(v == 8'h00, "R5 slave flag cleared", v, 0);

    // R10 slave frames in every mode
    for (int mode = 0; mode < 4; mode++) begin
      for (int p = 0; p < 2; p++) begin
        automatic logic [7:0] mb = 8'(8'h35 + 8'h41 * (mode * 2 + p));
        automatic logic [7:0] sb = 8'(8'hC1 + 8'h27 * (mode * 2 + p));
        tb_sck = mode[1];
        bus_wr(2'd0, 8'h40 | 8'(mode << 2));
        idle(4);
        bus_wr(2'd2, sb);
        ext_frame(mode[1], mode[0], mb, 8, seen, oe_seen);
        check(oe_seen == 1'b1, "R10 miso_oe while selected", oe_seen, 1);
        check(miso_oe == 1'b0, "R10 miso_oe released", miso_oe, 0);
        check(seen == sb, "R10 slave transmit", seen, sb);
        bus_rd(2'd1, v); check(v == 8'h80, "R10 done flag", v, 8'h80);
        bus_rd(2'd2, v); check(v == mb, "R10 slave receive", v, mb);
      end
    end

    // R11 slave abort mid-byte
    tb_sck = 1'b0;
    bus_wr(2'd0, 8'h40);
    idle(4);
    bus_wr(2'd2, 8'h00);
    ext_frame(1'b0, 1'b0, 8'hFF, 3, seen, oe_seen);
    bus_rd(2'd1, v); check(v == 8'h00, "R11 no done after abort", v, 0);
    ext_frame(1'b0, 1'b0, 8'hC3, 8, seen, oe_seen);
    bus_rd(2'd1, v); check(v == 8'h80, "R11 next frame completes", v, 8'h80);
    bus_rd(2'd2, v); check(v == 8'hC3, "R11 restarts at bit 0", v, 8'hC3);

    // R7 mode fault, R9 interrupt gating
    tb_ss = 1'b0;
    bus_wr(2'd0, 8'hD0);
    idle(4);
    check({sck_oe, mosi_oe} == 2'b00, "R7 pins released", {sck_oe, mosi_oe}, 0);
    check(irq == 1'b1, "R9 fault interrupt", irq, 1);
    bus_rd(2'd0, v); check(v == 8'h80, "R7 control bits cleared", v, 8'h80);
    bus_rd(2'd1, v); check(v == 8'h10, "R7 fault flag", v, 8'h10);
    irq_mask = 1'b1; idle(2);
    check(irq == 1'b0, "R9 masked", irq, 0);
    irq_mask = 1'b0; idle(2);
    check(irq == 1'b1, "R9 unmasked", irq, 1);
    bus_wr(2'd0, 8'h00);
    bus_rd(2'd1, v); check(v == 8'h00, "R7 fault cleared", v, 0);
    idle(2);
    check(irq == 1'b0, "R9 request drops", irq, 0);

    // R8 select pin as output, select input held low
    bus_wr(2'd0, 8'hF0);
    idle(4);
    bus_rd(2'd1, v); check(v == 8'h00, "R8 no fault", v, 0);
    check({ss_oe, ss_n_out} == 2'b11, "R8 select idle", {ss_oe, ss_n_out}, 2'b11);
    bus_wr(2'd2, 8'hA5);
    idle(3);
    check(ss_n_out == 1'b0, "R8 select active", ss_n_out, 0);
    idle(30);
    check(ss_n_out == 1'b1, "R8 select released", ss_n_out, 1);
    check(irq == 1'b1, "R9 done interrupt", irq, 1);
    bus_rd(2'd1, v); check(v == 8'h80, "R8 frame done", v, 8'h80);
    bus_rd(2'd2, v); check(v == 8'hA5, "R8 frame data", v, 8'hA5);
    idle(2);
    check(irq == 1'b0, "R9 cleared", irq, 0);

    bus_wr(2'd0, 8'h00);
    tb_ss = 1'b1;
    idle(4);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule